// File: doc/BRIEF.md
# Cache Line Refiller

This block brings one complete cache line in from memory and delivers it to its consumer as a series of fetch blocks. A refill begins when the consumer presents a byte address on the start handshake. The block discards the offset bits below the line size, so the address is treated as line-aligned. It then reads the line word by word as a Wishbone classic bus master.

Once all the words of a fetch block have been gathered, the block offers a result on the result handshake. Each result carries:
- the byte address of the block,
- the assembled block data,
- an error flag,
- a last flag.

The consumer takes results at its own pace. While a result is waiting, the bus stays idle.

A bus error ends the refill early. The block that saw the error is reported with both its error and last flags set, and no further words are read. The block takes no new start request until the final result of the current refill has been accepted. It holds no tags and applies no cache policy, so it serves as the line-fill engine under a cache controller.

Top module: `line_refill`

## Requirements
- R1: After reset, and after a reset raised in the middle of a refill, `start_ready` is 1 while `res_valid` and `wb_cyc` are 0.
- R2: An error-free refill yields exactly LINE_BYTES/BLOCK_BYTES results. Result i carries the address base + i×BLOCK_BYTES, and the results come out in ascending order. Here base is the start address with its low log2(LINE_BYTES) bits cleared.
- R3: Every bus read drives `wb_adr` with the byte address shifted right by log2(WORD_BYTES). It also drives `wb_we` = 0 and all `wb_sel` bits at 1. Within a line, the words are read in ascending order.
- R4: A result's data holds its words little-endian. The word at the lowest address sits in bits [WORD_W-1:0], and each following word sits in the next WORD_W bits.
- R5: A `wb_err` response on any word sets `res_err` and `res_last` on the result of that block. The refill then ends with no further bus read and no further result. The data of such a result is unspecified.
- R6: In an error-free refill, `res_last` is 1 on the final block of the line and 0 on every other block.
- R7: The slave may insert any number of wait cycles. While `wb_cyc` is high and neither `wb_ack` nor `wb_err` is high, the next cycle keeps `wb_cyc` high and `wb_adr` unchanged.
- R8: `start_ready` is 0 from the cycle after a request is accepted until the final result has been accepted. A `start_valid` raised during that time has no effect on the refill in progress.
- R9: While `res_valid` is 1 and `res_ready` is 0, the result fields stay unchanged and `wb_cyc` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Refill request present |
| start_ready | output | 1 | Refiller idle, request taken this cycle |
| start_addr | input | ADDR_W | Byte address inside the line to fetch |
| res_valid | output | 1 | A fetch block result is offered |
| res_ready | input | 1 | Consumer takes the offered result |
| res_addr | output | ADDR_W | Byte address of the offered block |
| res_data | output | BLOCK_BYTES×8 | Block data, lowest-addressed word in the low bits |
| res_err | output | 1 | A bus error hit this block |
| res_last | output | 1 | Final result of this refill |
| wb_cyc | output | 1 | Bus cycle active |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Write enable, always 0 |
| wb_sel | output | WORD_BYTES | Byte selects, all ones |
| wb_adr | output | ADDR_W-log2(WORD_BYTES) | Word address |
| wb_dat_i | input | WORD_BYTES×8 | Read data from the slave |
| wb_ack | input | 1 | Slave acknowledge |
| wb_err | input | 1 | Slave error response |

## Verification
The bench plays a slave whose wait count runs from zero to several cycles. This separates a block that samples data only on acknowledge from one that samples early, and it checks that the address is held during wait states. Start addresses are given both line-aligned and with stray offset bits, which shows whether the base is masked. Single bus errors are placed on the first word, on the second word of a middle block, and on the very last word of a line. These cases show whether the refill stops at the right block, and whether the error flag is tied to the block rather than to the line. Consumer stalls and repeated start requests during a refill show whether the block holds its result, keeps the bus idle and ignores requests while busy.

// File: rtl/refill_pkg.sv
package refill_pkg;

    typedef enum logic [1:0] {
        RF_IDLE = 2'd0,
        RF_BUS  = 2'd1,
        RF_HOLD = 2'd2
    } rf_state_e;

    // Width of an index counter that must count 0..n-1 (never below one bit).
    function automatic int cnt_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/refill_cursor.sv
module refill_cursor #(
    parameter int ADDR_W      = 32,
    parameter int WORD_BYTES  = 4,
    parameter int BLOCK_BYTES = 8,
    parameter int LINE_BYTES  = 32,
    localparam int WPB    = BLOCK_BYTES / WORD_BYTES,
    localparam int BPL    = LINE_BYTES / BLOCK_BYTES,
    localparam int WOFF   = $clog2(WORD_BYTES),
    localparam int BOFF   = $clog2(BLOCK_BYTES),
    localparam int WI_W   = refill_pkg::cnt_w(WPB),
    localparam int BI_W   = refill_pkg::cnt_w(BPL),
    localparam int WADR_W = ADDR_W - WOFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step_word,
    input  logic              step_block,
    output logic [ADDR_W-1:0] blk_addr,
    output logic [WADR_W-1:0] word_adr,
    output logic [WI_W-1:0]   word_idx,
    output logic              word_last,
    output logic              blk_last
);
    logic [ADDR_W-1:0] base_q;
    logic [BI_W-1:0]   blk_q;
    logic [WI_W-1:0]   wrd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            blk_q  <= '0;
            wrd_q  <= '0;
        end else if (load) begin
            base_q <= load_addr & ~ADDR_W'(LINE_BYTES - 1);
            blk_q  <= '0;
            wrd_q  <= '0;
        end else if (step_block) begin
            blk_q  <= blk_q + BI_W'(1);
            wrd_q  <= '0;
        end else if (step_word) begin
            wrd_q  <= wrd_q + WI_W'(1);
        end
    end

    always_comb begin
        blk_addr  = base_q + (ADDR_W'(blk_q) << BOFF);
        word_adr  = WADR_W'(blk_addr >> WOFF) + WADR_W'(wrd_q);
        word_idx  = wrd_q;
        word_last = (wrd_q == WI_W'(WPB - 1));
        blk_last  = (blk_q == BI_W'(BPL - 1));
    end
endmodule

// File: rtl/refill_collect.sv
module refill_collect #(
    parameter int WORD_W = 32,
    parameter int WPB    = 2,
    localparam int WI_W  = refill_pkg::cnt_w(WPB)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  capture,
    input  logic [WI_W-1:0]       lane_sel,
    input  logic [WORD_W-1:0]     word_in,
    output logic [WORD_W*WPB-1:0] block_out
);
    for (genvar g = 0; g < WPB; g++) begin : g_lane
        logic [WORD_W-1:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst)
                lane_q <= '0;
            else if (capture && lane_sel == WI_W'(g))
                lane_q <= word_in;
        end
        assign block_out[g*WORD_W +: WORD_W] = lane_q;
    end
endmodule

// File: rtl/line_refill.sv
module line_refill #(
    parameter int ADDR_W      = 32,
    parameter int WORD_BYTES  = 4,
    parameter int BLOCK_BYTES = 8,
    parameter int LINE_BYTES  = 32,
    localparam int WORD_W  = WORD_BYTES * 8,
    localparam int BLOCK_W = BLOCK_BYTES * 8,
    localparam int WPB     = BLOCK_BYTES / WORD_BYTES,
    localparam int WOFF    = $clog2(WORD_BYTES),
    localparam int WI_W    = refill_pkg::cnt_w(WPB),
    localparam int WADR_W  = ADDR_W - WOFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_valid,
    output logic               start_ready,
    input  logic [ADDR_W-1:0]  start_addr,
    output logic               res_valid,
    input  logic               res_ready,
    output logic [ADDR_W-1:0]  res_addr,
    output logic [BLOCK_W-1:0] res_data,
    output logic               res_err,
    output logic               res_last,
    output logic               wb_cyc,
    output logic               wb_stb,
    output logic               wb_we,
    output logic [WORD_BYTES-1:0] wb_sel,
    output logic [WADR_W-1:0]  wb_adr,
    input  logic [WORD_W-1:0]  wb_dat_i,
    input  logic               wb_ack,
    input  logic               wb_err
);
    import refill_pkg::*;

    rf_state_e       state_q, state_d;
    logic            err_q;
    logic            load, bus_done, word_step, to_hold, accept, next_block;
    logic            word_last, blk_last;
    logic [WI_W-1:0] word_idx;

    always_comb begin
        load       = (state_q == RF_IDLE) && start_valid;
        bus_done   = (state_q == RF_BUS) && (wb_ack || wb_err);
        word_step  = bus_done && !wb_err && !word_last;
        to_hold    = bus_done && (wb_err || word_last);
        accept     = (state_q == RF_HOLD) && res_ready;
        next_block = accept && !res_last;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RF_IDLE: if (load)       state_d = RF_BUS;
            RF_BUS:  if (to_hold)    state_d = RF_HOLD;
            RF_HOLD: if (accept)     state_d = res_last ? RF_IDLE : RF_BUS;
            default:                 state_d = RF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RF_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load || next_block)
                err_q <= 1'b0;
            else if (bus_done && wb_err)
                err_q <= 1'b1;
        end
    end

    refill_cursor #(
        .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES),
        .BLOCK_BYTES(BLOCK_BYTES), .LINE_BYTES(LINE_BYTES)
    ) cursor_i (
        .clk(clk), .rst(rst),
        .load(load), .load_addr(start_addr),
        .step_word(word_step), .step_block(next_block),
        .blk_addr(res_addr), .word_adr(wb_adr), .word_idx(word_idx),
        .word_last(word_last), .blk_last(blk_last)
    );

    refill_collect #(.WORD_W(WORD_W), .WPB(WPB)) collect_i (
        .clk(clk), .rst(rst),
        .capture(bus_done && !wb_err), .lane_sel(word_idx),
        .word_in(wb_dat_i), .block_out(res_data)
    );

    always_comb begin
        start_ready = (state_q == RF_IDLE);
        res_valid   = (state_q == RF_HOLD);
        res_err     = err_q;
        res_last    = blk_last || err_q;
        wb_cyc      = (state_q == RF_BUS);
        wb_stb      = (state_q == RF_BUS);
        wb_we       = 1'b0;
        wb_sel      = '1;
    end
endmodule

// File: rtl/line_refill_chk.sv
module line_refill_chk #(
    parameter int ADDR_W      = 32,
    parameter int WORD_BYTES  = 4,
    parameter int BLOCK_BYTES = 8,
    localparam int BLOCK_W = BLOCK_BYTES * 8,
    localparam int WADR_W  = ADDR_W - $clog2(WORD_BYTES),
    localparam int BOFF    = $clog2(BLOCK_BYTES)
) (
    input logic               clk,
    input logic               rst,
    input logic               start_ready,
    input logic               res_valid,
    input logic               res_ready,
    input logic [ADDR_W-1:0]  res_addr,
    input logic [BLOCK_W-1:0] res_data,
    input logic               res_err,
    input logic               res_last,
    input logic               wb_cyc,
    input logic [WADR_W-1:0]  wb_adr,
    input logic               wb_ack,
    input logic               wb_err
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (start_ready && !res_valid && !wb_cyc)); // R1

    AST_RES_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_addr[BOFF-1:0] == '0)); // R2

    AST_ERR_ENDS: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_err) |-> res_last); // R5

    AST_ADR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc && !wb_ack && !wb_err) |=> (wb_cyc && $stable(wb_adr))); // R7

    AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (rst)
        (res_valid || wb_cyc) |-> !start_ready); // R8

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_addr) &&
            $stable(res_data) && $stable(res_err) && $stable(res_last))); // R9

    AST_HOLD_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> !wb_cyc); // R9
endmodule

bind line_refill line_refill_chk #(
    .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .BLOCK_BYTES(BLOCK_BYTES)
) chk_i (
    .clk(clk), .rst(rst), .start_ready(start_ready),
    .res_valid(res_valid), .res_ready(res_ready), .res_addr(res_addr),
    .res_data(res_data), .res_err(res_err), .res_last(res_last),
    .wb_cyc(wb_cyc), .wb_adr(wb_adr), .wb_ack(wb_ack), .wb_err(wb_err)
);

// File: tb/line_refill_tb_top.sv
module line_refill_tb_top;
    localparam int ADDR_W = 32, WORD_BYTES = 4, BLOCK_BYTES = 8, LINE_BYTES = 32;
    localparam int WPB = BLOCK_BYTES / WORD_BYTES;
    localparam int BPL = LINE_BYTES / BLOCK_BYTES;
    localparam int WADR_W = ADDR_W - 2;

    logic clk = 1'b0, rst = 1'b1;
    logic start_valid = 1'b0, start_ready;
    logic [ADDR_W-1:0] start_addr = '0;
    logic res_valid, res_ready = 1'b0, res_err, res_last;
    logic [ADDR_W-1:0] res_addr;
    logic [63:0] res_data;
    logic wb_cyc, wb_stb, wb_we;
    logic [3:0] wb_sel;
    logic [WADR_W-1:0] wb_adr;
    logic [31:0] wb_dat_i;
    logic wb_ack, wb_err;

    always #5 clk = ~clk;

    line_refill #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES),
                  .BLOCK_BYTES(BLOCK_BYTES), .LINE_BYTES(LINE_BYTES)) dut_i (
        .clk(clk), .rst(rst), .start_valid(start_valid), .start_ready(start_ready),
        .start_addr(start_addr), .res_valid(res_valid), .res_ready(res_ready),
        .res_addr(res_addr), .res_data(res_data), .res_err(res_err), .res_last(res_last),
        .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_sel(wb_sel),
        .wb_adr(wb_adr), .wb_dat_i(wb_dat_i), .wb_ack(wb_ack), .wb_err(wb_err));

    int n_tests = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mem_word(input logic [WADR_W-1:0] a);
        return ({2'b00, a} * 32'h9E3779B1) ^ 32'h0BADF00D;
    endfunction

    // Slave model
    int slv_wait = 0;
    bit bad_en = 1'b0;
    logic [WADR_W-1:0] bad_wadr = '0;
    logic [WADR_W-1:0] exp_wadr = '0;

    initial begin
        int cnt;
        cnt = 0;
        wb_ack = 1'b0; wb_err = 1'b0; wb_dat_i = '0;
        forever begin
            @(negedge clk);
            if (wb_ack || wb_err) begin
                wb_ack = 1'b0; wb_err = 1'b0; cnt = 0;
            end else if (wb_cyc && wb_stb && !rst) begin
                if (cnt >= slv_wait) begin
                    // R3: word address sequence and read-only strobes
                    chk(wb_adr == exp_wadr && !wb_we && wb_sel == 4'hF, "R3 wb_adr",
                        64'(wb_adr), 64'(exp_wadr));
                    exp_wadr = exp_wadr + 1'b1;
                    if (bad_en && wb_adr == bad_wadr) wb_err = 1'b1;
                    else begin wb_ack = 1'b1; wb_dat_i = mem_word(wb_adr); end
                    cnt = 0;
                end else cnt++;
            end else cnt = 0;
        end
    end

    typedef struct packed {
        logic [31:0] addr;
        logic [3:0]  wait_n;
        logic        bad;
        logic [2:0]  bad_idx;
        logic [3:0]  stall;
        logic        spam;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{32'h0001_0000, 4'd0, 1'b0, 3'd0, 4'd0, 1'b0},
        '{32'h0001_0024, 4'd3, 1'b0, 3'd0, 4'd0, 1'b0},
        '{32'h0002_0040, 4'd1, 1'b1, 3'd0, 4'd0, 1'b0},
        '{32'h0003_0060, 4'd0, 1'b1, 3'd3, 4'd2, 1'b0},
        '{32'h0004_0000, 4'd2, 1'b1, 3'd7, 4'd0, 1'b0},
        '{32'h0005_00E0, 4'd5, 1'b0, 3'd0, 4'd3, 1'b0},
        '{32'h0006_0000, 4'd1, 1'b0, 3'd0, 4'd1, 1'b1}
    };

    task automatic run_refill(input vec_t v);
        logic [31:0] base;
        int nblk;
        base = v.addr & ~32'(LINE_BYTES - 1);
        slv_wait = int'(v.wait_n);
        bad_en = v.bad;
        bad_wadr = WADR_W'(base >> 2) + WADR_W'(v.bad_idx);
        exp_wadr = WADR_W'(base >> 2);
        nblk = v.bad ? (int'(v.bad_idx) / WPB + 1) : BPL;

        @(negedge clk);
        start_valid = 1'b1; start_addr = v.addr;
        @(negedge clk);
        start_valid = 1'b0;
        chk(!start_ready, "R8 busy after accept", 64'(start_ready), 64'd0);
        if (v.spam) begin start_valid = 1'b1; start_addr = 32'hDEAD_0000; end

        for (int i = 0; i < nblk; i++) begin
            int t;
            logic [31:0] ea, w0;
            logic [63:0] ed;
            bit eerr, elast, stable_ok;
            t = 0;
            while (!res_valid && t < 500) begin @(negedge clk); t++; end
            chk(res_valid, "R2 result offered", 64'(res_valid), 64'd1);
            ea = base + 32'(i * BLOCK_BYTES);
            w0 = base / 4 + 32'(i * WPB);
            ed = {mem_word(WADR_W'(w0 + 1)), mem_word(WADR_W'(w0))};
            eerr = v.bad && (i == nblk - 1);
            elast = (i == nblk - 1);
            chk(res_addr == ea, "R2 block address", 64'(res_addr), 64'(ea));
            chk(res_err == eerr, "R5 error flag", 64'(res_err), 64'(eerr));
            chk(res_last == elast, eerr ? "R5 last on error" : "R6 last flag",
                64'(res_last), 64'(elast));
            if (!eerr) chk(res_data == ed, "R4 block data", res_data, ed);
            if (v.spam) chk(!start_ready, "R8 request ignored while busy", 64'(start_ready), 64'd0);
            if (v.stall != 0) begin
                logic [31:0] a0; logic [63:0] d0; logic l0;
                a0 = res_addr; d0 = res_data; l0 = res_last;
                stable_ok = 1'b1;
                repeat (int'(v.stall)) begin
                    @(negedge clk);
                    if (!res_valid || res_addr != a0 || res_data != d0 ||
                        res_last != l0 || wb_cyc) stable_ok = 1'b0;
                end
                chk(stable_ok, "R9 stall holds result, bus idle", 64'(stable_ok), 64'd1);
            end
            if (elast) start_valid = 1'b0;
            res_ready = 1'b1;
            @(negedge clk);
            res_ready = 1'b0;
        end
        chk(start_ready && !res_valid && !wb_cyc,
            v.bad ? "R5 refill ended" : "R2 refill ended",
            {61'd0, start_ready, res_valid, wb_cyc}, 64'b100);
        bad_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(start_ready && !res_valid && !wb_cyc, "R1 reset state",
            {61'd0, start_ready, res_valid, wb_cyc}, 64'b100);
        rst = 1'b0;
        @(negedge clk);

        for (int k = 0; k < 7; k++) run_refill(VECS[k]);

        // R7: long wait states with a line ending address
        run_refill('{32'h0007_FFE0, 4'd9, 1'b0, 3'd0, 4'd0, 1'b0});

        // R1: reset in the middle of a refill
        slv_wait = 20;
        exp_wadr = WADR_W'(32'h0008_0000 >> 2);
        @(negedge clk); start_valid = 1'b1; start_addr = 32'h0008_0000;
        @(negedge clk); start_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(wb_cyc, "R7 bus held during waits", 64'(wb_cyc), 64'd1);
        rst = 1'b1;
        @(negedge clk);
        chk(start_ready && !res_valid && !wb_cyc, "R1 reset mid refill",
            {61'd0, start_ready, res_valid, wb_cyc}, 64'b100);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // after the reset a fresh refill runs normally
        run_refill('{32'h0009_0040, 4'd0, 1'b0, 3'd0, 4'd0, 1'b0});

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule